// File: doc/BRIEF.md
# QPSK direct-sequence spreading front end

This block is the digital front of a direct-sequence QPSK transmitter. A serial data stream arrives one bit per bit period. The block pairs consecutive bits into dibits. The first bit of each pair goes to the in-phase wire and the second bit goes to the quadrature wire. Each dibit is then held for two bit periods, and over that time each branch bit is spread into `N_CHIPS` chips by XOR with a pseudo-noise sequence. Each branch has its own sequence.

Everything runs on one clock at the chip rate. A chip counter produces the bit-rate and dibit-rate enables, so all three rates stay locked to one timebase. The upstream source watches `bit_stb` and presents a data bit in each cycle where it is high. Downstream shaping and mixing consume the two chip streams, or the antipodal levels, while `chip_vld` is high.

Top module: `qds_spread_front`

## Requirements
- R1: `chip_idx` counts 0, 1, …, `N_CHIPS`-1 and then wraps to 0, advancing once per clock. After `rst_n` is released it holds 0 through two synchronizing cycles. In the third cycle it shows 0 with strobes active.
- R2: `bit_stb` is high only in the cycles where `chip_idx` is 0 or `N_CHIPS`/2. `bit_in` is sampled only in those cycles, and its value in every other cycle has no effect on any output.
- R3: The bit sampled at `chip_idx` 0 appears on `par_i`. The bit sampled at `chip_idx` `N_CHIPS`/2 appears on `par_q`. Both appear from the next cycle with `chip_idx` 0, which is two bit periods after the first bit of the pair was sampled.
- R4: `par_i` and `par_q` stay constant for all `N_CHIPS` cycles of a dibit and change only where `chip_idx` is 0.
- R5: While valid, `i_chip` = `par_i` XOR PN_I[k], where k = `chip_idx`. The generator is defined as follows. From state s of width W, the chip is s[0] and the next state is {^(s & MASK), s[W-1:1]}. The I defaults are W=5, MASK=5'b00101 and seed 5'b00001.
- R6: Both PN generators restart from their seed at every dibit start, so chip 0 of every dibit uses the seed's bit 0.
- R7: `q_chip` = `par_q` XOR PN_Q[k], using the R5 formula with the Q defaults W=5, MASK=5'b01001 and seed 5'b10110. This gives a sequence different from PN_I.
- R8: `i_lvl` and `q_lvl` are 2-bit signed values. A chip of 0 maps to +1 (2'sb01) and a chip of 1 maps to -1 (2'sb11).
- R9: `chip_vld` is low until the first dibit is loaded and then stays high. While it is low, both chips are 0. `dibit_stb` is high exactly in the valid cycles with `chip_idx` 0.
- R10: Asserting `rst_n` low takes effect at once, without waiting for a clock. It clears `chip_vld`, `par_i`, `par_q`, `chip_idx`, `bit_stb`, `dibit_stb` and both chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_in | input | 1 | Serial data bit, sampled when `bit_stb` is high |
| bit_stb | output | 1 | High in cycles where `bit_in` is taken |
| dibit_stb | output | 1 | First chip of a newly presented dibit |
| chip_idx | output | $clog2(N_CHIPS) | Chip position within the dibit |
| chip_vld | output | 1 | Chip outputs carry spread data |
| par_i | output | 1 | Held in-phase (even) bit |
| par_q | output | 1 | Held quadrature (odd) bit |
| i_chip | output | 1 | In-phase chip |
| q_chip | output | 1 | Quadrature chip |
| i_lvl | output | 2 | Signed antipodal in-phase level |
| q_lvl | output | 2 | Signed antipodal quadrature level |

## Verification
Some properties can be checked in every cycle, and the assertions cover these. They check the counter stepping and wrap, that the held dibit stays constant inside a symbol, that chip 0 of each valid symbol uses the seed bit, the quiet outputs before the first dibit, and the alignment of the two strobes. Other behaviour depends on the data history, and only the bench scenarios can show it. This includes the routing of even and odd bits with the two-period latency, the full chip sequences of both branches, the fact that off-strobe input is ignored, and the asynchronous clear in the middle of a symbol. The bench covers random data, all-zero, all-one and alternating streams, and a reset that lands inside a dibit.

// File: rtl/qds_pkg.sv
package qds_pkg;

  // Antipodal level carried on the signed outputs.
  typedef logic signed [1:0] lvl_t;

  localparam lvl_t LVL_POS = 2'sb01;
  localparam lvl_t LVL_NEG = 2'sb11;

  // Parallel pair: in-phase (even) and quadrature (odd) bit.
  typedef struct packed {
    logic i;
    logic q;
  } dibit_t;

  function automatic lvl_t chip_to_lvl(input logic chip);
    return chip ? LVL_NEG : LVL_POS;
  endfunction

endpackage

// File: rtl/qds_rate_gen.sv
// Chip counter and the bit/dibit enables derived from it.
module qds_rate_gen #(
  parameter int N_CHIPS = 8,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          even_stb,
  output logic          odd_stb,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(N_CHIPS - 1);
  localparam logic [CW-1:0] HALF = CW'(N_CHIPS / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt      = cnt_q;
  assign even_stb = run & (cnt_q == '0);
  assign odd_stb  = run & (cnt_q == HALF);
  assign wrap     = run & (cnt_q == LAST);

endmodule

// File: rtl/qds_dibit_reg.sv
// Serial-to-parallel steering: even bit to I, odd bit to Q.
module qds_dibit_reg
  import qds_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_in,
  input  logic   even_stb,
  input  logic   odd_stb,
  input  logic   wrap,
  output dibit_t par,
  output logic   vld
);

  logic   even_q, even_d;
  logic   odd_q, odd_d;
  dibit_t par_q, par_d;
  logic   vld_q, vld_d;

  always_comb begin
    even_d = even_stb ? bit_in : even_q;
    // Bypass lets the odd bit land in the same cycle as the load (N_CHIPS = 2).
    odd_d  = odd_stb ? bit_in : odd_q;
    par_d  = par_q;
    vld_d  = vld_q;
    if (wrap) begin
      par_d.i = even_q;
      par_d.q = odd_d;
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q <= 1'b0;
      odd_q  <= 1'b0;
      par_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      even_q <= even_d;
      odd_q  <= odd_d;
      par_q  <= par_d;
      vld_q  <= vld_d;
    end
  end

  assign par = par_q;
  assign vld = vld_q;

endmodule

// File: rtl/qds_pn_lfsr.sv
// Fibonacci shift-register code generator, reloaded at each symbol start.
module qds_pn_lfsr #(
  parameter int           W    = 5,
  parameter logic [W-1:0] MASK = 5'b00101,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic chip
);

  if (W < 2) begin : g_bad_width
    $error("qds_pn_lfsr: W must be at least 2");
  end
  if (SEED == '0) begin : g_bad_seed
    $error("qds_pn_lfsr: SEED must be nonzero");
  end

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (restart) begin
      state_d = SEED;
    end else if (en) begin
      state_d = {^(state_q & MASK), state_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign chip = state_q[0];

endmodule

// File: rtl/qds_branch.sv
// One spreading branch: code generator, XOR with the held bit, level map.
module qds_branch
  import qds_pkg::*;
#(
  parameter int           W    = 5,
  parameter logic [W-1:0] MASK = 5'b00101,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic data,
  input  logic vld,
  output logic chip,
  output lvl_t lvl
);

  logic pn;

  qds_pn_lfsr #(
    .W    (W),
    .MASK (MASK),
    .SEED (SEED)
  ) u_pn (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .restart (restart),
    .chip    (pn)
  );

  assign chip = vld & (data ^ pn);
  assign lvl  = chip_to_lvl(chip);

endmodule

// File: rtl/qds_spread_front.sv
module qds_spread_front
  import qds_pkg::*;
#(
  parameter int               N_CHIPS = 8,
  parameter int               I_W     = 5,
  parameter logic [I_W-1:0]   I_MASK  = 5'b00101,
  parameter logic [I_W-1:0]   I_SEED  = 5'b00001,
  parameter int               Q_W     = 5,
  parameter logic [Q_W-1:0]   Q_MASK  = 5'b01001,
  parameter logic [Q_W-1:0]   Q_SEED  = 5'b10110,
  localparam int              CW      = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  output logic          bit_stb,
  output logic          dibit_stb,
  output logic [CW-1:0] chip_idx,
  output logic          chip_vld,
  output logic          par_i,
  output logic          par_q,
  output logic          i_chip,
  output logic          q_chip,
  output logic signed [1:0] i_lvl,
  output logic signed [1:0] q_lvl
);

  if ((N_CHIPS < 2) || ((N_CHIPS % 2) != 0)) begin : g_bad_chips
    $error("qds_spread_front: N_CHIPS must be even and at least 2");
  end

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync_q[1];

  logic          even_stb;
  logic          odd_stb;
  logic          wrap;
  logic [CW-1:0] cnt;
  dibit_t        par;
  logic          vld;
  lvl_t          i_lvl_w;
  lvl_t          q_lvl_w;

  qds_rate_gen #(
    .N_CHIPS (N_CHIPS),
    .CW      (CW)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (rst_s_n),
    .cnt      (cnt),
    .even_stb (even_stb),
    .odd_stb  (odd_stb),
    .wrap     (wrap)
  );

  qds_dibit_reg u_dibit (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .bit_in   (bit_in),
    .even_stb (even_stb),
    .odd_stb  (odd_stb),
    .wrap     (wrap),
    .par      (par),
    .vld      (vld)
  );

  qds_branch #(
    .W    (I_W),
    .MASK (I_MASK),
    .SEED (I_SEED)
  ) u_br_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (rst_s_n),
    .restart (wrap),
    .data    (par.i),
    .vld     (vld),
    .chip    (i_chip),
    .lvl     (i_lvl_w)
  );

  qds_branch #(
    .W    (Q_W),
    .MASK (Q_MASK),
    .SEED (Q_SEED)
  ) u_br_q (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (rst_s_n),
    .restart (wrap),
    .data    (par.q),
    .vld     (vld),
    .chip    (q_chip),
    .lvl     (q_lvl_w)
  );

  assign bit_stb   = even_stb | odd_stb;
  assign dibit_stb = vld & even_stb;
  assign chip_idx  = cnt;
  assign chip_vld  = vld;
  assign par_i     = par.i;
  assign par_q     = par.q;
  assign i_lvl     = i_lvl_w;
  assign q_lvl     = q_lvl_w;

endmodule

// File: rtl/qds_spread_chk.sv
module qds_spread_chk #(
  parameter int   N_CHIPS = 8,
  parameter int   CW      = 3,
  parameter logic I_SEED0 = 1'b1,
  parameter logic Q_SEED0 = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_stb,
  input logic          dibit_stb,
  input logic [CW-1:0] chip_idx,
  input logic          chip_vld,
  input logic          par_i,
  input logic          par_q,
  input logic          i_chip,
  input logic          q_chip
);

  localparam logic [CW-1:0] LAST = CW'(N_CHIPS - 1);

  // R1: counter steps by one inside a symbol
  p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && (chip_idx != LAST)) |=> (chip_idx == $past(chip_idx) + 1'b1));

  // R1: counter wraps after the last chip
  p_idx_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && (chip_idx == LAST)) |=> (chip_idx == '0));

  // R4: dibit held inside a symbol
  p_par_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && (chip_idx != '0)) |-> ($stable(par_i) && $stable(par_q)));

  // R6: chip 0 of every symbol uses the seed bit
  p_seed_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_vld && (chip_idx == '0)) |->
      ((i_chip == (par_i ^ I_SEED0)) && (q_chip == (par_q ^ Q_SEED0))));

  // R9: valid rises on a symbol start
  p_vld_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_vld) |-> (dibit_stb && (chip_idx == '0)));

  // R9: quiet outputs before the first dibit
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_vld |-> (!i_chip && !q_chip && !dibit_stb));

  // R2: symbol start is also a bit-sampling cycle
  p_stb_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dibit_stb |-> bit_stb);

endmodule

bind qds_spread_front qds_spread_chk #(
  .N_CHIPS (N_CHIPS),
  .CW      (CW),
  .I_SEED0 (I_SEED[0]),
  .Q_SEED0 (Q_SEED[0])
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_stb   (bit_stb),
  .dibit_stb (dibit_stb),
  .chip_idx  (chip_idx),
  .chip_vld  (chip_vld),
  .par_i     (par_i),
  .par_q     (par_q),
  .i_chip    (i_chip),
  .q_chip    (q_chip)
);

// File: tb/test_qds_spread_front.sv
`timescale 1ns/1ps
module test_qds_spread_front;

  localparam int N = 8;
  localparam int H = N / 2;
  localparam logic [4:0] I_MASK = 5'b00101;
  localparam logic [4:0] I_SEED = 5'b00001;
  localparam logic [4:0] Q_MASK = 5'b01001;
  localparam logic [4:0] Q_SEED = 5'b10110;

  logic clk;
  logic rst_n;
  logic bit_in;
  logic bit_stb;
  logic dibit_stb;
  logic [2:0] chip_idx;
  logic chip_vld;
  logic par_i;
  logic par_q;
  logic i_chip;
  logic q_chip;
  logic signed [1:0] i_lvl;
  logic signed [1:0] q_lvl;

  int errs;
  int checks;
  bit done;
  bit bits [0:511];
  bit pn_i [0:N-1];
  bit pn_q [0:N-1];

  qds_spread_front i_qds_spread_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_in    (bit_in),
    .bit_stb   (bit_stb),
    .dibit_stb (dibit_stb),
    .chip_idx  (chip_idx),
    .chip_vld  (chip_vld),
    .par_i     (par_i),
    .par_q     (par_q),
    .i_chip    (i_chip),
    .q_chip    (q_chip),
    .i_lvl     (i_lvl),
    .q_lvl     (q_lvl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit pn_at(input logic [4:0] seed, input logic [4:0] mask, input int k);
    logic [4:0] s;
    s = seed;
    for (int j = 0; j < k; j++) s = {^(s & mask), s[4:1]};
    return s[0];
  endfunction

  function automatic int lvl_exp(input bit c);
    return c ? -1 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic check_cleared(input string what);
    chk(chip_vld == 1'b0, {"R10 chip_vld ", what}, chip_vld, 0);
    chk(par_i == 1'b0 && par_q == 1'b0, {"R10 par ", what}, {par_i, par_q}, 0);
    chk(chip_idx == 3'd0, {"R10 chip_idx ", what}, chip_idx, 0);
    chk(bit_stb == 1'b0 && dibit_stb == 1'b0, {"R10 strobes ", what}, {bit_stb, dibit_stb}, 0);
    chk(i_chip == 1'b0 && q_chip == 1'b0, {"R10 chips ", what}, {i_chip, q_chip}, 0);
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(negedge clk);
    check_cleared("held");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(bit_stb == 1'b0 && chip_idx == 3'd0, "R1 sync hold", {bit_stb, chip_idx}, 0);
    @(posedge clk);
  endtask

  // mode: 0 random, 1 zeros, 2 ones, 3 alternating; rst_at >= 0 cuts in with reset
  task automatic run_phase(input int nd, input int mode, input int rst_at);
    for (int i = 0; i < 2 * nd; i++) begin
      case (mode)
        1: bits[i] = 1'b0;
        2: bits[i] = 1'b1;
        3: bits[i] = i[0];
        default: bits[i] = 1'($urandom);
      endcase
    end
    for (int c = 0; c < nd * N; c++) begin
      int k;
      int p;
      bit di;
      bit dq;
      bit ei;
      bit eq;
      @(negedge clk);
      k = c % N;
      p = c / N;
      chk(chip_idx == 3'(k), "R1 chip_idx", chip_idx, k);
      chk(bit_stb == ((k == 0) || (k == H)), "R2 bit_stb", bit_stb, (k == 0) || (k == H));
      chk(chip_vld == (p >= 1), "R9 chip_vld", chip_vld, p >= 1);
      chk(dibit_stb == ((p >= 1) && (k == 0)), "R9 dibit_stb", dibit_stb, (p >= 1) && (k == 0));
      if (p >= 1) begin
        di = bits[2 * (p - 1)];
        dq = bits[2 * (p - 1) + 1];
        ei = di ^ pn_i[k];
        eq = dq ^ pn_q[k];
        if (k == 0) begin
          chk(par_i == di, "R3 even bit to par_i", par_i, di);
          chk(par_q == dq, "R3 odd bit to par_q", par_q, dq);
          chk(i_chip == (di ^ I_SEED[0]), "R6 I restart", i_chip, di ^ I_SEED[0]);
          chk(q_chip == (dq ^ Q_SEED[0]), "R6 Q restart", q_chip, dq ^ Q_SEED[0]);
        end else begin
          chk(par_i == di && par_q == dq, "R4 dibit held", {par_i, par_q}, {di, dq});
        end
        chk(i_chip == ei, "R5 i_chip", i_chip, ei);
        chk(q_chip == eq, "R7 q_chip", q_chip, eq);
        chk(int'(i_lvl) == lvl_exp(ei), "R8 i_lvl", int'(i_lvl), lvl_exp(ei));
        chk(int'(q_lvl) == lvl_exp(eq), "R8 q_lvl", int'(q_lvl), lvl_exp(eq));
      end else begin
        chk(i_chip == 1'b0 && q_chip == 1'b0, "R9 quiet chips", {i_chip, q_chip}, 0);
      end
      if (c == rst_at) begin
        rst_n = 1'b0;
        #1;
        check_cleared("async mid-dibit");
        return;
      end
      if (k == 0) bit_in = bits[2 * p];
      else if (k == H) bit_in = bits[2 * p + 1];
      else bit_in = 1'($urandom);  // R2: off-strobe value must be ignored
    end
  endtask

  initial begin
    errs   = 0;
    checks = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    bit_in = 1'b0;
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) begin
      pn_i[k] = pn_at(I_SEED, I_MASK, k);
      pn_q[k] = pn_at(Q_SEED, Q_MASK, k);
    end
    do_reset();
    run_phase(40, 0, -1);
    do_reset();
    run_phase(6, 1, -1);
    do_reset();
    run_phase(6, 2, -1);
    do_reset();
    run_phase(6, 3, -1);
    do_reset();
    run_phase(5, 0, 21);
    do_reset();
    run_phase(20, 0, -1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule